// File: doc/BRIEF.md
# Wrap Burst Translator

This block sits between a source that issues wrapping bursts and a target bus that cannot wrap and that takes write bursts of at most eight words. A source command carries a start address, a length code and a direction. The block accepts one command at a time and turns it into one or two linear target transactions. Every word is 32 bits wide.

For a write, the block first collects every source beat into a small reorder store. It then sends the data to the target starting at the wrap boundary, so the target sees plain incrementing bursts. A sixteen-word write goes out as two eight-word bursts: the first has address bit 5 clear and the second has it set. For a read, the block issues the first target read at the source start address. If that address is not on the wrap boundary, it issues a second read from the boundary. The returned words then arrive in the order the source expects, and the block forwards them straight through. A marker flags the final beat.

All data channels use valid/ready. A beat moves on a cycle where both valid and ready are high. Once an output's valid is raised, the block holds it and its payload unchanged until ready is seen. The source may hold back write data, the target may hold back commands and write data, and the source may hold back read data. On the read path the block passes back-pressure straight through to the target.

Top module: `wbt_top`

## Requirements
- R1: After reset, s_cmd_ready is 1 and t_cmd_valid, t_wvalid and s_rvalid are 0.
- R2: The length code s_cmd_len is beats minus one and only takes 1, 3, 7 or 15. The wrap boundary is the start address aligned down to beats×4 bytes. Address bits [1:0] are ignored, and every target address has them at 0.
- R3: A write of 2, 4 or 8 beats becomes one target burst with t_cmd_write=1, starting at the wrap boundary, with t_cmd_beats equal to the beat count.
- R4: A 16-beat write becomes two 8-beat target bursts. The first is at the boundary (address bit 5 clear) and the second is at the boundary plus 32 (bit 5 set). No write burst exceeds 8 beats.
- R5: Each target write beat carries the source beat whose wrap address equals that target beat's address. t_wlast is 1 exactly on the final beat of each target burst.
- R6: A read that starts on the wrap boundary becomes one target read (t_cmd_write=0) of the full beat count at the start address.
- R7: A read at word offset k≠0 within the wrap becomes two target reads. The first is N−k beats at the start address and the second is k beats at the boundary.
- R8: A target transaction of one word has t_cmd_single=1 and t_cmd_beats=1. Every longer one has t_cmd_single=0.
- R9: Read words reach the source in target order, which is wrap order with the requested word first. s_rlast is 1 only on the N-th beat.
- R10: While a valid output is stalled, it stays high and its payload stays unchanged. This applies to t_cmd_*, t_wdata/t_wlast and the forwarded s_rdata.
- R11: s_cmd_ready is 0 from the cycle after a command is accepted until the transaction ends. A write ends when its final target write beat is accepted. A read ends shortly after its final source read beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_cmd_valid | input | 1 | Source command valid |
| s_cmd_ready | output | 1 | Source command ready (idle) |
| s_cmd_addr | input | 32 | Start byte address |
| s_cmd_len | input | 4 | Beats minus one (1, 3, 7, 15) |
| s_cmd_write | input | 1 | 1 = write, 0 = read |
| s_wvalid | input | 1 | Source write data valid |
| s_wready | output | 1 | Source write data ready |
| s_wdata | input | 32 | Source write word, in wrap order |
| s_rvalid | output | 1 | Read return valid |
| s_rready | input | 1 | Read return ready |
| s_rdata | output | 32 | Read return word |
| s_rlast | output | 1 | Final read return beat |
| t_cmd_valid | output | 1 | Target command valid |
| t_cmd_ready | input | 1 | Target command ready |
| t_cmd_addr | output | 32 | Target start address |
| t_cmd_beats | output | 5 | Target transfer length in words |
| t_cmd_single | output | 1 | One-word single transfer |
| t_cmd_write | output | 1 | Target direction, 1 = write |
| t_wvalid | output | 1 | Target write data valid |
| t_wready | input | 1 | Target write data ready |
| t_wdata | output | 32 | Target write word |
| t_wlast | output | 1 | Final beat of a target write burst |
| t_rvalid | input | 1 | Target read data valid |
| t_rready | output | 1 | Target read data ready |
| t_rdata | input | 32 | Target read word |

## Verification
The bench sweeps every beat count and every starting word offset, in both directions. Each data word is a hash of its own address, so a wrong slot in the reorder store shows up as a target beat whose data belongs to another address. A boundary computed with the wrong mask moves the target addresses. The 16-beat write catches a second burst that misses bit 5 or a t_wlast placed only at the end. The offset sweep on reads catches a wrong split length, a one-word piece issued as a burst, and s_rlast on the wrong beat. Stalls on every channel expose payloads that change while valid waits. Low address bits set to non-zero values catch a design that passes them to the target.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int MAX_BEATS  = 16;
  localparam int LEN_W      = $clog2(MAX_BEATS);
  localparam int CNT_W      = LEN_W + 1;
  localparam int TGT_WR_MAX = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  beats;
  } piece_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WCOL,
    ST_CMD,
    ST_WSEND,
    ST_RWAIT
  } state_t;
endpackage

// File: rtl/wbt_plan.sv
module wbt_plan
  import wbt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              is_write,
  output piece_t            p0,
  output piece_t            p1,
  output logic              two,
  output logic [LEN_W-1:0]  off
);
  logic [ADDR_W-1:0] span_mask;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] word_addr;
  logic [CNT_W-1:0]  nb;

  always_comb begin
    nb        = CNT_W'(len) + CNT_W'(1);
    span_mask = {{(ADDR_W-LEN_W-2){1'b0}}, len, 2'b11};
    word_addr = {addr[ADDR_W-1:2], 2'b00};
    base      = addr & ~span_mask;
    off       = addr[LEN_W+1:2] & len;
    p0        = '0;
    p1        = '0;
    two       = 1'b0;
    if (is_write) begin
      // writes always start on the boundary; long ones split in halves
      p0.addr = base;
      if (nb > CNT_W'(TGT_WR_MAX)) begin
        p0.beats = CNT_W'(TGT_WR_MAX);
        p1.addr  = base + ADDR_W'(TGT_WR_MAX * 4);
        p1.beats = CNT_W'(TGT_WR_MAX);
        two      = 1'b1;
      end else begin
        p0.beats = nb;
      end
    end else if (off == '0) begin
      p0.addr  = base;
      p0.beats = nb;
    end else begin
      // read: from the requested word up to the boundary, then the rest
      p0.addr  = word_addr;
      p0.beats = nb - CNT_W'(off);
      p1.addr  = base;
      p1.beats = CNT_W'(off);
      two      = 1'b1;
    end
  end
endmodule

// File: rtl/wbt_wbuf.sv
module wbt_wbuf
  import wbt_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LEN_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] slot [MAX_BEATS];

  for (genvar i = 0; i < MAX_BEATS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == LEN_W'(i))) slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/wbt_rret.sv
module wbt_rret
  import wbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic             last,
  output logic             done
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (fire) begin
      cnt <= cnt + LEN_W'(1);
      if (cnt == len) done <= 1'b1;
    end
  end

  assign last = (cnt == len);

  AST_NO_EXTRA_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !done); // R9
endmodule

// File: rtl/wbt_top.sv
module wbt_top
  import wbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cmd_valid,
  output logic              s_cmd_ready,
  input  logic [ADDR_W-1:0] s_cmd_addr,
  input  logic [LEN_W-1:0]  s_cmd_len,
  input  logic              s_cmd_write,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [WORD_W-1:0] s_wdata,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [WORD_W-1:0] s_rdata,
  output logic              s_rlast,
  output logic              t_cmd_valid,
  input  logic              t_cmd_ready,
  output logic [ADDR_W-1:0] t_cmd_addr,
  output logic [CNT_W-1:0]  t_cmd_beats,
  output logic              t_cmd_single,
  output logic              t_cmd_write,
  output logic              t_wvalid,
  input  logic              t_wready,
  output logic [WORD_W-1:0] t_wdata,
  output logic              t_wlast,
  input  logic              t_rvalid,
  output logic              t_rready,
  input  logic [WORD_W-1:0] t_rdata
);
  state_t           state;
  logic             wr_q, two_q, pi;
  logic [LEN_W-1:0] len_q, off_q, wcnt, ptr;
  piece_t           pc0, pc1;

  piece_t           pl0, pl1;
  logic             pl_two;
  logic [LEN_W-1:0] pl_off;

  logic             accept, rd_active, r_fire, r_last, r_done;
  piece_t           cur;

  wbt_plan u_plan (
    .addr    (s_cmd_addr),
    .len     (s_cmd_len),
    .is_write(s_cmd_write),
    .p0      (pl0),
    .p1      (pl1),
    .two     (pl_two),
    .off     (pl_off)
  );

  wbt_wbuf u_wbuf (
    .clk    (clk),
    .wr_en  (state == ST_WCOL && s_wvalid),
    .wr_idx ((off_q + wcnt) & len_q),
    .wr_data(s_wdata),
    .rd_idx (ptr),
    .rd_data(t_wdata)
  );

  wbt_rret u_rret (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .fire (r_fire),
    .len  (len_q),
    .last (r_last),
    .done (r_done)
  );

  assign accept      = (state == ST_IDLE) && s_cmd_valid;
  assign s_cmd_ready = (state == ST_IDLE);
  assign s_wready    = (state == ST_WCOL);

  assign cur          = pi ? pc1 : pc0;
  assign t_cmd_valid  = (state == ST_CMD);
  assign t_cmd_addr   = cur.addr;
  assign t_cmd_beats  = cur.beats;
  assign t_cmd_single = (cur.beats == CNT_W'(1));
  assign t_cmd_write  = wr_q;

  assign t_wvalid = (state == ST_WSEND);
  assign t_wlast  = pi ? (ptr == len_q)
                       : (CNT_W'(ptr) == pc0.beats - CNT_W'(1));

  assign rd_active = !wr_q && !r_done && (state == ST_CMD || state == ST_RWAIT);
  assign s_rvalid  = t_rvalid && rd_active;
  assign t_rready  = s_rready && rd_active;
  assign s_rdata   = t_rdata;
  assign s_rlast   = r_last && s_rvalid;
  assign r_fire    = s_rvalid && s_rready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wr_q  <= 1'b0;
      two_q <= 1'b0;
      pi    <= 1'b0;
      len_q <= '0;
      off_q <= '0;
      wcnt  <= '0;
      ptr   <= '0;
      pc0   <= '0;
      pc1   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (s_cmd_valid) begin
          wr_q  <= s_cmd_write;
          len_q <= s_cmd_len;
          off_q <= pl_off;
          pc0   <= pl0;
          pc1   <= pl1;
          two_q <= pl_two;
          pi    <= 1'b0;
          wcnt  <= '0;
          ptr   <= '0;
          state <= s_cmd_write ? ST_WCOL : ST_CMD;
        end
        ST_WCOL: if (s_wvalid) begin
          wcnt <= wcnt + LEN_W'(1);
          if (wcnt == len_q) state <= ST_CMD;
        end
        ST_CMD: if (t_cmd_ready) begin
          if (wr_q)              state <= ST_WSEND;
          else if (pi == two_q)  state <= ST_RWAIT;
          else                   pi    <= 1'b1;
        end
        ST_WSEND: if (t_wready) begin
          ptr <= ptr + LEN_W'(1);
          if (t_wlast) begin
            if (pi == two_q) state <= ST_IDLE;
            else begin
              pi    <= 1'b1;
              state <= ST_CMD;
            end
          end
        end
        ST_RWAIT: if (r_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (s_cmd_len == 4'd1 || s_cmd_len == 4'd3 ||
                s_cmd_len == 4'd7 || s_cmd_len == 4'd15)); // R2
  AST_WR_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (t_cmd_valid && t_cmd_write) |-> (t_cmd_beats <= CNT_W'(TGT_WR_MAX))); // R4
  AST_READ_PIECES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (t_cmd_valid && !t_cmd_write) |->
      (pc0.beats + (two_q ? pc1.beats : CNT_W'(0)) == CNT_W'(len_q) + CNT_W'(1))); // R7
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (t_cmd_valid && !t_cmd_ready) |=>
      (t_cmd_valid && $stable(t_cmd_addr) && $stable(t_cmd_beats))); // R10
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (t_wvalid && !t_wready) |=>
      (t_wvalid && $stable(t_wdata) && $stable(t_wlast))); // R10
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cmd_valid && s_cmd_ready) |=> !s_cmd_ready); // R11
endmodule

// File: tb/sim_wbt_top.sv
module sim_wbt_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_cmd_valid = 1'b0, s_cmd_ready;
  logic [31:0] s_cmd_addr = '0;
  logic [3:0]  s_cmd_len = '0;
  logic        s_cmd_write = 1'b0;
  logic        s_wvalid = 1'b0, s_wready;
  logic [31:0] s_wdata = '0;
  logic        s_rvalid, s_rready = 1'b0, s_rlast;
  logic [31:0] s_rdata;
  logic        t_cmd_valid, t_cmd_ready = 1'b0;
  logic [31:0] t_cmd_addr;
  logic [4:0]  t_cmd_beats;
  logic        t_cmd_single, t_cmd_write;
  logic        t_wvalid, t_wready = 1'b0, t_wlast;
  logic [31:0] t_wdata;
  logic        t_rvalid = 1'b0, t_rready;
  logic [31:0] t_rdata = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] rq [16];
  int rq_n;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wbt_top u0 (.*);

  function automatic logic [31:0] dat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input bit wr, input int n, input int o, input int t);
    logic [31:0] base, addr;
    logic [31:0] ea [2];
    int eb [2];
    int np;
    base = 32'h2000_0000 + 32'(t) * 32'h100;
    addr = base + 32'(o * 4) + 32'(t % 4);
    np = 1; ea[0] = base; eb[0] = n; ea[1] = '0; eb[1] = 0;
    if (wr && n > 8) begin
      np = 2; eb[0] = 8; ea[1] = base + 32; eb[1] = 8;
    end else if (!wr && o != 0) begin
      np = 2; ea[0] = base + 32'(o * 4); eb[0] = n - o; ea[1] = base; eb[1] = o;
    end
    rq_n = 0;
    fork
      begin : src_cmd
        @(negedge clk);
        s_cmd_valid = 1; s_cmd_addr = addr; s_cmd_len = 4'(n - 1); s_cmd_write = wr;
        #1;
        while (!s_cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk); s_cmd_valid = 0; #1;
        chk(s_cmd_ready == 0, "R11 busy", 32'(s_cmd_ready), 0);
      end
      begin : src_w
        if (wr) begin
          int k = 0;
          while (k < n) begin
            @(negedge clk);
            if (cyc % 4 == 1) s_wvalid = 0;
            else begin
              s_wvalid = 1;
              s_wdata = dat(base + 32'(((o + k) % n) * 4));
              #1;
              if (s_wready) k++;
            end
          end
          @(negedge clk); s_wvalid = 0;
        end
      end
      begin : tgt_cmd
        for (int p = 0; p < np; p++) begin
          bit got = 0, pend = 0;
          logic [31:0] pa;
          while (!got) begin
            @(negedge clk);
            t_cmd_ready = (cyc % 3 != 0);
            #1;
            if (t_cmd_valid && !t_cmd_ready) begin pend = 1; pa = t_cmd_addr; end
            if (t_cmd_valid && t_cmd_ready) begin
              got = 1;
              if (pend) chk(t_cmd_addr == pa, "R10 cmd hold", t_cmd_addr, pa);
              chk(t_cmd_addr == ea[p], wr ? (n > 8 ? "R4 addr" : "R3 addr") : (o != 0 ? "R7 addr" : "R6 addr"), t_cmd_addr, ea[p]);
              chk(t_cmd_addr[1:0] == 2'b00, "R2 low bits", t_cmd_addr, ea[p]);
              chk(32'(t_cmd_beats) == 32'(eb[p]), wr ? (n > 8 ? "R4 beats" : "R3 beats") : (o != 0 ? "R7 beats" : "R6 beats"), 32'(t_cmd_beats), 32'(eb[p]));
              chk(t_cmd_single == (eb[p] == 1), "R8 single", 32'(t_cmd_single), 32'(eb[p] == 1));
              chk(t_cmd_write == wr, "R3 direction", 32'(t_cmd_write), 32'(wr));
            end
          end
          @(negedge clk); t_cmd_ready = 0;
          if (wr) begin
            int k = 0;
            bit wp = 0;
            logic [31:0] wd = '0;
            while (k < eb[p]) begin
              if (k > 0 || wp) @(negedge clk);
              t_wready = (cyc % 5 != 2);
              #1;
              if (t_wvalid && !t_wready) begin wp = 1; wd = t_wdata; end
              if (t_wvalid && t_wready) begin
                if (wp) chk(t_wdata == wd, "R10 wdata hold", t_wdata, wd);
                wp = 0;
                chk(t_wdata == dat(ea[p] + 32'(k * 4)), "R5 data", t_wdata, dat(ea[p] + 32'(k * 4)));
                chk(t_wlast == (k == eb[p] - 1), "R5 wlast", 32'(t_wlast), 32'(k == eb[p] - 1));
                k++;
              end
            end
            @(negedge clk); t_wready = 0;
          end else begin
            for (int k = 0; k < eb[p]; k++) rq[rq_n + k] = dat(ea[p] + 32'(k * 4));
            rq_n = rq_n + eb[p];
          end
        end
      end
      begin : tgt_r
        if (!wr) begin
          int h = 0;
          while (h < n) begin
            @(negedge clk);
            if (h < rq_n) begin
              t_rvalid = 1; t_rdata = rq[h];
              #1;
              if (t_rready) h++;
            end else t_rvalid = 0;
          end
          @(negedge clk); t_rvalid = 0;
        end
      end
      begin : src_r
        if (!wr) begin
          int k = 0;
          bit rp = 0;
          logic [31:0] rd = '0;
          while (k < n) begin
            @(negedge clk);
            s_rready = (cyc % 7 != 3);
            #1;
            if (s_rvalid && !s_rready) begin rp = 1; rd = s_rdata; end
            if (s_rvalid && s_rready) begin
              if (rp) chk(s_rdata == rd, "R10 rdata hold", s_rdata, rd);
              rp = 0;
              chk(s_rdata == dat(base + 32'(((o + k) % n) * 4)), "R9 data", s_rdata, dat(base + 32'(((o + k) % n) * 4)));
              chk(s_rlast == (k == n - 1), "R9 rlast", 32'(s_rlast), 32'(k == n - 1));
              k++;
            end
          end
          @(negedge clk); s_rready = 0;
        end
      end
    join
    repeat (3) @(negedge clk);
    #1;
    chk(s_cmd_ready == 1, "R11 completion", 32'(s_cmd_ready), 1);
  endtask

  initial begin
    int t = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(s_cmd_ready == 1, "R1 ready", 32'(s_cmd_ready), 1);
    chk(t_cmd_valid == 0, "R1 cmd", 32'(t_cmd_valid), 0);
    chk(t_wvalid == 0, "R1 wvalid", 32'(t_wvalid), 0);
    chk(s_rvalid == 0, "R1 rvalid", 32'(s_rvalid), 0);
    for (int w = 0; w < 2; w++) begin
      for (int lc = 0; lc < 4; lc++) begin
        for (int o = 0; o < (2 << lc); o++) begin
          run(w[0], 2 << lc, o, t);
          t++;
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule